// File: doc/BRIEF.md
# Two-Level Local Branch Direction Predictor

This block predicts whether a conditional branch is taken. Each branch maps to one slot of a small table, selected by low program-counter bits. A slot holds a shift register with that branch's last few outcomes. It also holds its own set of two-bit saturating counters, one for every possible history value. The current history of the slot chooses which counter gives the prediction. Because of this, a branch with a repeating outcome pattern, such as taken on every third execution, can be learned. A predictor indexed by address alone cannot learn such a pattern.

The fetch side presents a PC on the lookup port and gets a prediction in the same cycle, before the instruction is decoded. The execute side reports resolved branches on the update port, giving the branch PC and the actual outcome. The update trains the selected counter and then shifts the outcome into that slot's history. There are no tags, so branches that share index bits share a slot. The defaults are 16 slots and a 4-bit history, which gives 16 counters per slot.

Top module: `local_hist_predictor`

## Requirements
- R1: The slot index is PC bits [PC_SKIP +: log2(NUM_ENTRIES)] (bits [5:2] by default). All other PC bits have no effect on the lookup or on the update.
- R2: Each update shifts the outcome (1 = taken, 0 = not taken) into the least significant bit of that slot's history and drops the oldest bit.
- R3: After reset every history is 0 and every counter is in state 01, so every lookup predicts not taken.
- R4: On update, the counter selected by the slot and its current history counts up on taken and down on not taken. It saturates at 3 and at 0.
- R5: The prediction is the most significant bit of the counter selected by {slot, slot history}, so states 10 and 11 predict taken. History value 0 selects the first counter of the slot and all ones selects the last.
- R6: The lookup is combinational. An update in the same cycle to the same slot does not change that cycle's prediction, and its effect is visible from the next cycle.
- R7: While up_valid is low, no history or counter changes, whatever up_pc and up_taken carry.
- R8: An update changes only the slot addressed by its PC. The predictions of other slots are unchanged.
- R9: A branch that repeats not taken, not taken, taken is predicted with no misses once training has settled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | PC of the branch being looked up |
| lk_taken | output | 1 | Predicted direction for lk_pc (1 = taken) |
| up_valid | input | 1 | Update request is valid this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Resolved outcome (1 = taken) |

## Verification
A mixed stream across four slots, with PCs whose upper and lowest bits vary, is compared against a bench-side model of histories and counters. This exposes errors in indexing, shifting and counter stepping. Long runs of one outcome on a single slot drive a counter into both saturation limits and return to it. This separates saturating counters from wrapping counters. A same-cycle lookup and update on one slot shows whether the old or the new value is read. The three-step repeating pattern shows whether history actually selects the counter: after warm-up it gives zero misses, which an address-only scheme cannot achieve.

// File: rtl/lhp_pkg.sv
package lhp_pkg;

    localparam int DEF_ENTRIES   = 16;
    localparam int DEF_HIST_BITS = 4;
    localparam int DEF_PC_W      = 32;
    localparam int DEF_PC_SKIP   = 2;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_T    = 2'd2,
        CTR_STRONG_T  = 2'd3
    } ctr_e;

    localparam ctr_e CTR_RESET = CTR_WEAK_NT;

    // Saturating step of a two-bit direction counter
    function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
        ctr_e nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_STRONG_T) nxt = ctr_e'(cur + 2'd1);
        end else begin
            if (cur != CTR_STRONG_NT) nxt = ctr_e'(cur - 2'd1);
        end
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(input ctr_e c);
        return c[1];
    endfunction

endpackage

// File: rtl/lhp_hist_bank.sv
module lhp_hist_bank #(
    parameter int NUM_ENTRIES = 16,
    parameter int HIST_BITS   = 4,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [HIST_BITS-1:0] rd_hist,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic                 wr_taken,
    output logic [HIST_BITS-1:0] wr_hist
);

    logic [HIST_BITS-1:0] hist_q [NUM_ENTRIES];
    logic [HIST_BITS-1:0] hist_shifted;

    assign rd_hist = hist_q[rd_idx];
    assign wr_hist = hist_q[wr_idx];

    generate
        if (HIST_BITS == 1) begin : g_one_bit
            assign hist_shifted = wr_taken;
        end else begin : g_multi_bit
            assign hist_shifted = {wr_hist[HIST_BITS-2:0], wr_taken};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ENTRIES; i++) hist_q[i] <= '0;
        end else if (wr_en) begin
            hist_q[wr_idx] <= hist_shifted;
        end
    end

endmodule

// File: rtl/lhp_ctr_bank.sv
module lhp_ctr_bank
    import lhp_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int HIST_BITS   = 4,
    localparam int IDX_W      = $clog2(NUM_ENTRIES),
    localparam int ADDR_W     = IDX_W + HIST_BITS,
    localparam int NUM_CTRS   = NUM_ENTRIES << HIST_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IDX_W-1:0]     rd_idx,
    input  logic [HIST_BITS-1:0] rd_hist,
    output ctr_e                 rd_state,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [HIST_BITS-1:0] wr_hist,
    input  logic                 wr_taken,
    output ctr_e                 wr_state
);

    ctr_e              ctr_q [NUM_CTRS];
    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] wr_addr;
    ctr_e              wr_next;

    // Slot-major layout: each slot owns a contiguous run of 2^HIST_BITS counters
    assign rd_addr  = {rd_idx, rd_hist};
    assign wr_addr  = {wr_idx, wr_hist};
    assign rd_state = ctr_q[rd_addr];
    assign wr_state = ctr_q[wr_addr];
    assign wr_next  = ctr_step(wr_state, wr_taken);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_CTRS; i++) ctr_q[i] <= CTR_RESET;
        end else if (wr_en) begin
            ctr_q[wr_addr] <= wr_next;
        end
    end

endmodule

// File: rtl/local_hist_predictor.sv
module local_hist_predictor
    import lhp_pkg::*;
#(
    parameter int NUM_ENTRIES = DEF_ENTRIES,
    parameter int HIST_BITS   = DEF_HIST_BITS,
    parameter int PC_W        = DEF_PC_W,
    parameter int PC_SKIP     = DEF_PC_SKIP
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken
);

    localparam int IDX_W = $clog2(NUM_ENTRIES);
    localparam int IDX_HI = PC_SKIP + IDX_W;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic             taken;
    } upd_t;

    logic [IDX_W-1:0]     lk_idx;
    logic [HIST_BITS-1:0] lk_hist;
    ctr_e                 lk_state;
    upd_t                 upd;
    logic [HIST_BITS-1:0] up_hist;
    ctr_e                 up_state;
    logic                 pc_bits_unused;

    assign lk_idx = lk_pc[PC_SKIP +: IDX_W];
    assign upd    = '{en: up_valid, idx: up_pc[PC_SKIP +: IDX_W], taken: up_taken};

    assign pc_bits_unused = ^{lk_pc[PC_W-1:IDX_HI], lk_pc[PC_SKIP-1:0],
                              up_pc[PC_W-1:IDX_HI], up_pc[PC_SKIP-1:0]};

    lhp_hist_bank #(
        .NUM_ENTRIES(NUM_ENTRIES),
        .HIST_BITS  (HIST_BITS)
    ) u_hist (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (lk_idx),
        .rd_hist (lk_hist),
        .wr_en   (upd.en),
        .wr_idx  (upd.idx),
        .wr_taken(upd.taken),
        .wr_hist (up_hist)
    );

    lhp_ctr_bank #(
        .NUM_ENTRIES(NUM_ENTRIES),
        .HIST_BITS  (HIST_BITS)
    ) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (lk_idx),
        .rd_hist (lk_hist),
        .rd_state(lk_state),
        .wr_en   (upd.en),
        .wr_idx  (upd.idx),
        .wr_hist (up_hist),
        .wr_taken(upd.taken),
        .wr_state(up_state)
    );

    assign lk_taken = ctr_says_taken(lk_state);

endmodule

// File: rtl/lhp_checker.sv
module lhp_checker #(
    parameter int HIST_BITS = 4,
    parameter int PC_W      = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic [PC_W-1:0]      lk_pc,
    input logic                 lk_taken,
    input logic                 up_valid,
    input logic [PC_W-1:0]      up_pc,
    input logic                 up_taken,
    input logic [HIST_BITS-1:0] up_hist,
    input logic [1:0]           up_state
);

    logic [HIST_BITS-1:0] hist_expect;
    logic [1:0]           inc_expect;
    logic [1:0]           dec_expect;

    assign hist_expect = HIST_BITS'({up_hist, up_taken});
    assign inc_expect  = (up_state == 2'd3) ? 2'd3 : up_state + 2'd1;
    assign dec_expect  = (up_state == 2'd0) ? 2'd0 : up_state - 2'd1;

    a_r3_reset_not_taken: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !lk_taken);

    a_r2_hist_shift: assert property (@(posedge clk) disable iff (rst)
        (up_valid && $past(up_valid) && !$past(rst) && up_pc == $past(up_pc))
        |-> up_hist == $past(hist_expect));

    a_r4_inc_saturate: assert property (@(posedge clk) disable iff (rst)
        ($past(up_valid && up_taken && (&up_hist)) && !$past(rst) &&
         up_valid && up_pc == $past(up_pc))
        |-> up_state == $past(inc_expect));

    a_r4_dec_saturate: assert property (@(posedge clk) disable iff (rst)
        ($past(up_valid && !up_taken && (up_hist == '0)) && !$past(rst) &&
         up_valid && up_pc == $past(up_pc))
        |-> up_state == $past(dec_expect));

    a_r6_same_cycle_old: assert property (@(posedge clk) disable iff (rst)
        (up_valid && lk_pc == up_pc) |-> lk_taken == up_state[1]);

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(up_valid) && !$past(rst) && lk_pc == $past(lk_pc))
        |-> $stable(lk_taken));

endmodule

bind local_hist_predictor lhp_checker #(
    .HIST_BITS(HIST_BITS),
    .PC_W     (PC_W)
) u_lhp_chk (
    .clk     (clk),
    .rst     (rst),
    .lk_pc   (lk_pc),
    .lk_taken(lk_taken),
    .up_valid(up_valid),
    .up_pc   (up_pc),
    .up_taken(up_taken),
    .up_hist (up_hist),
    .up_state(up_state)
);

// File: tb/local_hist_predictor_test.sv
module local_hist_predictor_test;

    localparam int CLK_PERIOD = 10;
    localparam int N_ENT = 16;
    localparam int HB    = 4;
    localparam int PCW   = 32;
    localparam int N_VEC = 24;

    // {slot[3:0], outcome}
    localparam logic [4:0] VEC [N_VEC] = '{
        {4'd1, 1'b1}, {4'd1, 1'b1}, {4'd2, 1'b0}, {4'd3, 1'b0}, {4'd1, 1'b0}, {4'd3, 1'b0},
        {4'd2, 1'b1}, {4'd3, 1'b0}, {4'd1, 1'b1}, {4'd3, 1'b0}, {4'd3, 1'b1}, {4'd2, 1'b1},
        {4'd0, 1'b1}, {4'd0, 1'b0}, {4'd0, 1'b1}, {4'd0, 1'b0}, {4'd2, 1'b1}, {4'd0, 1'b1},
        {4'd0, 1'b0}, {4'd1, 1'b1}, {4'd2, 1'b0}, {4'd0, 1'b1}, {4'd0, 1'b0}, {4'd3, 1'b1}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [PCW-1:0] lk_pc = '0;
    logic [PCW-1:0] up_pc = '0;
    logic           up_valid = 1'b0;
    logic           up_taken = 1'b0;
    logic           lk_taken;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [HB-1:0] m_hist [N_ENT];
    logic [1:0]    m_ctr  [N_ENT][1 << HB];

    always #(CLK_PERIOD / 2) clk = ~clk;

    local_hist_predictor #(
        .NUM_ENTRIES(N_ENT),
        .HIST_BITS  (HB),
        .PC_W       (PCW),
        .PC_SKIP    (2)
    ) uut (
        .clk     (clk),
        .rst     (rst),
        .lk_pc   (lk_pc),
        .lk_taken(lk_taken),
        .up_valid(up_valid),
        .up_pc   (up_pc),
        .up_taken(up_taken)
    );

    task automatic model_reset();
        for (int e = 0; e < N_ENT; e++) begin
            m_hist[e] = '0;
            for (int h = 0; h < (1 << HB); h++) m_ctr[e][h] = 2'b01;
        end
    endtask

    function automatic logic model_pred(input logic [PCW-1:0] pc);
        return m_ctr[pc[5:2]][m_hist[pc[5:2]]][1];
    endfunction

    task automatic model_update(input logic [PCW-1:0] pc, input logic t);
        logic [3:0]    e;
        logic [HB-1:0] h;
        e = pc[5:2];
        h = m_hist[e];
        if (t && m_ctr[e][h] != 2'b11) m_ctr[e][h] = m_ctr[e][h] + 2'b01;
        if (!t && m_ctr[e][h] != 2'b00) m_ctr[e][h] = m_ctr[e][h] - 2'b01;
        m_hist[e] = {h[HB-2:0], t};
    endtask

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Lookup and update the same PC in one cycle; check the pre-update prediction
    task automatic step(input logic [PCW-1:0] pc, input logic t, input string tag,
                        output logic seen);
        @(negedge clk);
        lk_pc    = pc;
        up_pc    = pc;
        up_taken = t;
        up_valid = 1'b1;
        #1;
        seen = lk_taken;
        check(lk_taken, model_pred(pc), tag);
        @(posedge clk);
        #1;
        model_update(pc, t);
        up_valid = 1'b0;
    endtask

    task automatic peek(input logic [PCW-1:0] pc, input logic exp, input string tag);
        @(negedge clk);
        lk_pc    = pc;
        up_valid = 1'b0;
        #1;
        check(lk_taken, exp, tag);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual %0d expected below 20000", cycles);
            summary();
            $finish;
        end
    end

    initial begin
        logic seen;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R3: all slots predict not taken out of reset
        for (int e = 0; e < N_ENT; e++) peek(PCW'(e * 4), 1'b0, "R3 reset state");

        // Table walk, R1 R2 R4 R5 against the model; upper and low PC bits vary
        for (int i = 0; i < N_VEC; i++) begin
            step({26'(i), VEC[i][4:1], 2'b01}, VEC[i][0], "R5 table walk", seen);
        end

        // R4: saturate upward on slot 5, then come back to the same counter
        for (int k = 0; k < 8; k++) step(32'h14, 1'b1, "R4 taken run", seen);
        peek(32'h14, 1'b1, "R4 saturated high");
        step(32'h14, 1'b0, "R4 step down", seen);
        peek(32'h14, 1'b0, "R5 history 1110 counter");
        for (int k = 0; k < 4; k++) step(32'h14, 1'b1, "R2 refill history", seen);
        peek(32'h14, 1'b1, "R4 no wrap at 3");

        // R6: same-cycle update not visible, visible next cycle (slot 9)
        for (int k = 0; k < 4; k++) step(32'h24, 1'b1, "R2 fill slot 9", seen);
        step(32'h24, 1'b1, "R6 same cycle", seen);
        check(seen, 1'b0, "R6 old value in update cycle");
        peek(32'h24, 1'b1, "R6 new value next cycle");

        // R7: update port driven but not valid
        @(negedge clk);
        up_pc    = 32'h24;
        up_taken = 1'b0;
        up_valid = 1'b0;
        repeat (5) @(posedge clk);
        peek(32'h24, 1'b1, "R7 invalid update ignored");

        // R1 aliasing and R8 independence
        peek(32'h8000_0024, 1'b1, "R1 upper bits ignored");
        peek(32'h0000_0027, 1'b1, "R1 low bits ignored");
        peek(32'h0000_0028, 1'b0, "R8 untouched slot 10");
        peek(32'h0000_0004, model_pred(32'h4), "R8 slot 1 unchanged");

        // R9: repeating 0,0,1 on slot 12
        for (int k = 0; k < 36; k++) begin
            step(32'h30, (k % 3) == 2, "R9 pattern vs model", seen);
            if (k >= 24) check(seen, (k % 3) == 2, "R9 pattern no miss");
        end

        // R3: reset again after training
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        model_reset();
        peek(32'h24, 1'b0, "R3 reset clears trained slot");
        peek(32'h14, 1'b0, "R3 reset clears slot 5");

        summary();
        $finish;
    end

endmodule